// File: doc/BRIEF.md
# Interrupt Routing Register File

This block is the register file seen by software in an I/O interrupt redirection controller with a parameterised number of input pins (24 by default). The bus reaches it through two decoded offsets: a select register that holds an index, and a data window whose meaning depends on that index. Through the window software reaches a 4-bit controller ID, a read-only version word, an arbitration word that mirrors the ID, and one 64-bit routing entry per pin. Each entry is read and written 32 bits at a time, and the parity of the select value picks the upper or the lower half.

The stored entries drive per-pin configuration outputs: vector, delivery mode, destination mode, polarity, trigger mode, mask and destination. Two status bits in each entry come from the delivery logic rather than from storage. Those are the remote-IRR flag and the busy (delivery status) flag. Rewriting an entry can have side effects, and each one is shown as a one-cycle pulse. A lower-half write asks for the pin's remote-IRR flag to be cleared. A change of the mask bit raises a notification with the pin number and the new mask value. A write that leaves a level-triggered entry whose pin request is pending raises a re-service request.

Top module: `irq_route_regs`

## Requirements
- R1: Only the low 8 bits of `bus_addr` are decoded. Offset 0x00 is the select register and offset 0x10 is the data window. A read at any other offset returns zero, and a write there changes no state.
- R2: A write takes effect only when `bus_len` is 4 or 8, and only `bus_wdata[31:0]` is used. A write with any other length changes no state.
- R3: Window index 0 is the ID. A write stores data bits 27:24, and a read returns the ID in bits 27:24 with every other bit zero.
- R4: Window index 1 reads (pin count − 1) in bits 23:16 and the `VERSION` parameter in bits 7:0, with all other bits zero. Writes to it change nothing.
- R5: Window index 2 reads the same value as index 0. Writes to it change nothing.
- R6: An index s ≥ 0x10 addresses the entry for pin (s − 0x10) >> 1. An odd s reaches bits 63:32 and an even s reaches bits 31:0. The entry fields are: vector [7:0], delivery mode [10:8], destination mode [11], busy [12], polarity [13], remote IRR [14], trigger mode [15] (1 = level), mask [16] and destination [63:56]. Bits 12 and 14 read back from `busy_in` and `remote_irr_in`. A write to a pin at or beyond the pin count is ignored, and a read of such a pin returns zero.
- R7: A write to the lower half of an entry pulses `rirr_clr` for that pin for exactly the cycle after the write.
- R8: When an entry write changes the mask bit, `mask_evt` pulses for one cycle after the write. During that pulse `mask_evt_pin` holds the pin and `mask_evt_val` holds the new mask.
- R9: After any entry write that leaves the entry level-triggered while the pin's `irr_in` bit is set, `svc_req` pulses for one cycle and `svc_pin` holds the pin.
- R10: After reset the select register and the ID are zero, every entry reads 0x0001_0000 in its lower half (masked, all other bits zero), and no pulse is active.
- R11: A read at offset 0x00 returns the full 32-bit value last written to the select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe for a write; reads are combinational on the address |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; only the low 8 bits are decoded |
| bus_len | input | 4 | Access length in bytes |
| bus_wdata | input | 64 | Write data; bits 31:0 are used |
| bus_rdata | output | 32 | Read data for the current address and select |
| irr_in | input | NUM_PINS | Pending request per pin |
| remote_irr_in | input | NUM_PINS | Remote-IRR status per pin |
| busy_in | input | NUM_PINS | Delivery-in-progress status per pin |
| pin_vector | output | 8·NUM_PINS | Vector per pin, packed 8 bits each |
| pin_dlv_mode | output | 3·NUM_PINS | Delivery mode per pin |
| pin_dest_mode | output | NUM_PINS | Destination mode per pin |
| pin_polarity | output | NUM_PINS | Polarity per pin |
| pin_level | output | NUM_PINS | Trigger mode per pin, 1 = level |
| pin_mask | output | NUM_PINS | Mask per pin |
| pin_dest | output | 8·NUM_PINS | Destination per pin |
| rirr_clr | output | NUM_PINS | One-cycle remote-IRR clear request |
| mask_evt | output | 1 | One-cycle mask-change notification |
| mask_evt_pin | output | PIN_W | Pin of the mask change |
| mask_evt_val | output | 1 | New mask value |
| svc_req | output | 1 | One-cycle re-service request |
| svc_pin | output | PIN_W | Pin to re-service |

## Verification
A single lower-half write can raise the remote-IRR clear, the mask notification and the re-service request in the same cycle. The bench provokes this by holding `irr_in` high for a pin and writing that pin's lower half with the trigger set to level while flipping the mask. It then checks all three pulses, and the pin numbers they carry, in the one cycle after the write. Further writes separate the three: rewriting the same value, writing the upper half, and choosing an edge trigger each show one or two of the pulses while the others stay low.

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
  parameter int          NUM_PINS = 24,
  parameter logic [7:0]  VERSION  = 8'h11,
  parameter int          ADDR_W   = 12,
  localparam int         PIN_W    = $clog2(NUM_PINS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [3:0]              bus_len,
  input  logic [63:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [NUM_PINS-1:0]     irr_in,
  input  logic [NUM_PINS-1:0]     remote_irr_in,
  input  logic [NUM_PINS-1:0]     busy_in,
  output logic [NUM_PINS*8-1:0]   pin_vector,
  output logic [NUM_PINS*3-1:0]   pin_dlv_mode,
  output logic [NUM_PINS-1:0]     pin_dest_mode,
  output logic [NUM_PINS-1:0]     pin_polarity,
  output logic [NUM_PINS-1:0]     pin_level,
  output logic [NUM_PINS-1:0]     pin_mask,
  output logic [NUM_PINS*8-1:0]   pin_dest,
  output logic [NUM_PINS-1:0]     rirr_clr,
  output logic                    mask_evt,
  output logic [PIN_W-1:0]        mask_evt_pin,
  output logic                    mask_evt_val,
  output logic                    svc_req,
  output logic [PIN_W-1:0]        svc_pin
);

  localparam logic [7:0]  PIN_MAX   = 8'(NUM_PINS - 1);
  localparam logic [63:0] ENT_RESET = 64'h0000_0000_0001_0000;
  localparam logic [31:0] TBL_BASE  = 32'h10;

  logic [31:0] sel_q;
  logic [3:0]  id_q;
  logic [63:0] tbl_q [NUM_PINS];

  logic [7:0]  offs;
  logic        hit_sel, hit_win, wr_ok;
  logic [31:0] wd, idx_full;
  logic        ent_ok, hi_half, ent_wr;
  logic [PIN_W-1:0] ent_idx;
  logic [63:0] cur_ent, new_ent, view_ent;

  assign offs     = bus_addr[7:0];
  assign hit_sel  = offs == 8'h00;
  assign hit_win  = offs == 8'h10;
  assign wr_ok    = bus_valid && bus_write && (bus_len == 4'd4 || bus_len == 4'd8);
  assign wd       = bus_wdata[31:0];
  assign idx_full = (sel_q - TBL_BASE) >> 1;
  assign ent_ok   = (sel_q >= TBL_BASE) && (idx_full < 32'(NUM_PINS));
  assign ent_idx  = idx_full[PIN_W-1:0];
  assign hi_half  = sel_q[0];
  assign ent_wr   = wr_ok && hit_win && ent_ok;

  assign cur_ent  = ent_ok ? tbl_q[ent_idx] : ENT_RESET;
  assign new_ent  = hi_half ? {wd, cur_ent[31:0]} : {cur_ent[63:32], wd};
  assign view_ent = {cur_ent[63:15], remote_irr_in[ent_idx], cur_ent[13],
                     busy_in[ent_idx], cur_ent[11:0]};

  always_comb begin
    bus_rdata = '0;
    if (hit_sel) begin
      bus_rdata = sel_q;
    end else if (hit_win) begin
      case (sel_q)
        32'd0, 32'd2: bus_rdata = {4'h0, id_q, 24'h0};
        32'd1:        bus_rdata = {8'h0, PIN_MAX, 8'h0, VERSION};
        default:      if (ent_ok) bus_rdata = hi_half ? view_ent[63:32] : view_ent[31:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else if (wr_ok) begin
      if (hit_sel) sel_q <= wd;
      if (hit_win && sel_q == 32'd0) id_q <= wd[27:24];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PINS; i++) tbl_q[i] <= ENT_RESET;
    end else if (ent_wr) begin
      tbl_q[ent_idx] <= new_ent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rirr_clr     <= '0;
      mask_evt     <= 1'b0;
      mask_evt_pin <= '0;
      mask_evt_val <= 1'b0;
      svc_req      <= 1'b0;
      svc_pin      <= '0;
    end else begin
      rirr_clr <= '0;
      mask_evt <= 1'b0;
      svc_req  <= 1'b0;
      if (ent_wr) begin
        if (!hi_half) rirr_clr[ent_idx] <= 1'b1;
        if (new_ent[16] != cur_ent[16]) begin
          mask_evt     <= 1'b1;
          mask_evt_pin <= ent_idx;
          mask_evt_val <= new_ent[16];
        end
        if (new_ent[15] && irr_in[ent_idx]) begin
          svc_req <= 1'b1;
          svc_pin <= ent_idx;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign pin_vector[g*8 +: 8]   = tbl_q[g][7:0];
    assign pin_dlv_mode[g*3 +: 3] = tbl_q[g][10:8];
    assign pin_dest_mode[g]       = tbl_q[g][11];
    assign pin_polarity[g]        = tbl_q[g][13];
    assign pin_level[g]           = tbl_q[g][15];
    assign pin_mask[g]            = tbl_q[g][16];
    assign pin_dest[g*8 +: 8]     = tbl_q[g][63:56];
  end

  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ok && hit_win && sel_q == 32'd0) |=> $stable(id_q)); // R3
  AST_RIRR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rirr_clr)); // R7
  AST_RIRR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rirr_clr) |-> $past(wr_ok && hit_win && !sel_q[0])); // R7
  AST_MASK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt |-> pin_mask[mask_evt_pin] == mask_evt_val); // R8
  AST_MASK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt |-> $past(bus_valid && bus_write)); // R8
  AST_SVC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> pin_level[svc_pin]); // R9
  AST_SVC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> $past(wr_ok && hit_win)); // R9

endmodule

// File: tb/test_irq_route_regs.sv
module test_irq_route_regs;
  localparam int NP = 24;
  localparam int PW = $clog2(NP);

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [3:0]  bus_len = 4'd4;
  logic [63:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] irr_in = '0, remote_irr_in = '0, busy_in = '0;
  logic [NP*8-1:0] pin_vector, pin_dest;
  logic [NP*3-1:0] pin_dlv_mode;
  logic [NP-1:0] pin_dest_mode, pin_polarity, pin_level, pin_mask, rirr_clr;
  logic mask_evt, mask_evt_val, svc_req;
  logic [PW-1:0] mask_evt_pin, svc_pin;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  irq_route_regs i_irq_route_regs (
    .clk, .rst_n, .bus_valid, .bus_write, .bus_addr, .bus_len, .bus_wdata, .bus_rdata,
    .irr_in, .remote_irr_in, .busy_in, .pin_vector, .pin_dlv_mode, .pin_dest_mode,
    .pin_polarity, .pin_level, .pin_mask, .pin_dest, .rirr_clr, .mask_evt,
    .mask_evt_pin, .mask_evt_val, .svc_req, .svc_pin);

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [63:0] d, logic [3:0] len = 4'd4);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_len = len; bus_write = 1'b1; bus_valid = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R10 events", {rirr_clr, mask_evt, svc_req}, '0);
    check("R10 masks", pin_mask, {NP{1'b1}});
    rd(12'h000, d); check("R10 select", d, 0);
    rd(12'h010, d); check("R10 id", d, 0);
    wr(12'h000, 64'h10);
    rd(12'h010, d); check("R10 entry0 low", d, 32'h0001_0000);
  endtask

  task automatic t_decode;
    logic [31:0] d;
    wr(12'h000, 64'h1234_5635);
    rd(12'h000, d); check("R11 select readback", d, 32'h1234_5635);
    rd(12'h020, d); check("R1 other offset read", d, 0);
    wr(12'h020, 64'h0);
    rd(12'h000, d); check("R1 other offset write", d, 32'h1234_5635);
    wr(12'h100, 64'h2);
    rd(12'h000, d); check("R1 high address bits dropped", d, 32'h2);
  endtask

  task automatic t_id;
    logic [31:0] d;
    wr(12'h000, 64'h0);
    wr(12'h010, 64'hFFFF_FFFF_A5FF_FFFF);
    rd(12'h010, d); check("R3 id", d, 32'h0500_0000);
    wr(12'h000, 64'h2);
    rd(12'h010, d); check("R5 arb read", d, 32'h0500_0000);
    wr(12'h010, 64'h0F00_0000);
    rd(12'h010, d); check("R5 arb write ignored", d, 32'h0500_0000);
  endtask

  task automatic t_version;
    logic [31:0] d;
    wr(12'h000, 64'h1);
    rd(12'h010, d); check("R4 version", d, 32'h0017_0011);
    wr(12'h010, 64'hFFFF_FFFF);
    rd(12'h010, d); check("R4 write ignored", d, 32'h0017_0011);
    wr(12'h000, 64'h0);
    rd(12'h010, d); check("R4 id untouched", d, 32'h0500_0000);
  endtask

  task automatic t_size;
    logic [31:0] d;
    wr(12'h010, 64'h0C00_0000, 4'd2);
    rd(12'h010, d); check("R2 short write dropped", d, 32'h0500_0000);
    wr(12'h010, 64'hFFFF_FFFF_0900_0000, 4'd8);
    rd(12'h010, d); check("R2 eight-byte write low half", d, 32'h0900_0000);
    wr(12'h000, 64'h3, 4'd1);
    rd(12'h000, d); check("R2 byte select write dropped", d, 0);
  endtask

  task automatic t_entry;
    logic [31:0] d;
    wr(12'h000, 64'h16);
    wr(12'h010, 64'h0000_A931);
    check("R7 clear pulse pin3", rirr_clr, 24'h8);
    check("R8 mask event", {mask_evt, 3'b0, mask_evt_pin, mask_evt_val}, {1'b1, 3'b0, 5'd3, 1'b0});
    check("R9 no service without irr", svc_req, 0);
    check("R6 fields pin3", {pin_vector[24 +: 8], pin_dlv_mode[9 +: 3], pin_dest_mode[3],
          pin_polarity[3], pin_level[3], pin_mask[3]}, {8'h31, 3'd1, 4'b1110});
    @(negedge clk);
    check("R7 pulse lasts one cycle", {rirr_clr, mask_evt}, '0);
    wr(12'h000, 64'h17);
    wr(12'h010, 64'hC400_0000);
    check("R7 no clear on high half", {rirr_clr, mask_evt}, '0);
    check("R6 destination", pin_dest[24 +: 8], 8'hC4);
    rd(12'h010, d); check("R6 high readback", d, 32'hC400_0000);
    remote_irr_in[3] = 1'b1; busy_in[3] = 1'b1;
    wr(12'h000, 64'h16);
    rd(12'h010, d); check("R6 status bits from inputs", d, 32'h0000_F931);
    remote_irr_in[3] = 1'b0; busy_in[3] = 1'b0;
    wr(12'h000, 64'h3E);
    wr(12'h010, 64'h0000_0077);
    check("R6 last pin written", {pin_vector[184 +: 8], rirr_clr[23]}, {8'h77, 1'b1});
    wr(12'h000, 64'h40);
    wr(12'h010, 64'h0000_0055);
    check("R6 out of range write ignored", {rirr_clr, mask_evt, svc_req}, '0);
    rd(12'h010, d); check("R6 out of range read zero", d, 0);
  endtask

  task automatic t_collide;
    irr_in[5] = 1'b1;
    wr(12'h000, 64'h1A);
    wr(12'h010, 64'h0000_8022);
    check("R7 R8 R9 same cycle", {rirr_clr[5], mask_evt, mask_evt_val, svc_req},
          {1'b1, 1'b1, 1'b0, 1'b1});
    check("R8 R9 pins", {3'b0, mask_evt_pin, 3'b0, svc_pin}, {3'b0, 5'd5, 3'b0, 5'd5});
    wr(12'h010, 64'h0000_8022);
    check("R9 service without mask change", {mask_evt, svc_req}, 2'b01);
    wr(12'h010, 64'h0001_8022);
    check("R8 mask set event", {mask_evt, mask_evt_val, svc_req}, 3'b111);
    wr(12'h000, 64'h1B);
    wr(12'h010, 64'h0100_0000);
    check("R9 high half service", {rirr_clr, mask_evt, svc_req}, {24'h0, 2'b01});
    wr(12'h000, 64'h1A);
    wr(12'h010, 64'h0000_0022);
    check("R9 edge entry no service", {mask_evt, mask_evt_val, svc_req}, 3'b100);
    irr_in[5] = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_decode;
    t_id;
    t_version;
    t_size;
    t_entry;
    t_collide;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule